// File: doc/BRIEF.md
# Protected Watchdog Configuration Register

This block is the control register of a watchdog timer, together with a small counter that makes the chosen timeout visible. Software writes one byte that holds a change-enable flag, an enable flag and a three-bit prescaler select. Turning the watchdog off, and at the stricter levels also changing its timeout, only works inside a short window that opens when the change-enable flag is written to one. Hardware closes that window by itself after four clocks.

Two static configuration inputs set a safety level. With `compat_cfg` high and `always_on_cfg` low the level is 0. In that level the prescaler may be rewritten freely, and the watchdog starts disabled. With both inputs low the level is 1. The watchdog starts disabled, and both disabling it and changing the prescaler need the window. With `always_on_cfg` high the level is 2, whatever `compat_cfg` is. The watchdog starts enabled, it can never be turned off, and a prescaler change needs the window.

The usual unlock is two writes. The first writes change-enable and enable both to one. The second follows within the window with change-enable at zero and carries the new enable and prescaler values. The counter advances on every clock while the watchdog is effectively enabled. A kick or an accepted change of the enable or prescaler value restarts it from zero. It emits a one-cycle timeout pulse each time it has counted 2^(BASE_EXP+prescaler) cycles.

Top module: `wdog_cfg_reg`

## Requirements
- R1: After reset the register reads 0x00 at levels 0 and 1 and 0x08 at level 2, and `wd_active` is 0 at levels 0 and 1 and 1 at level 2.
- R2: Read data places change-enable in bit 4, enable in bit 3 and the prescaler in bits 2..0. Bits 7..5 always read as zero.
- R3: A write with bit 4 set opens the change window. Bit 4 then reads 1 for exactly four cycles and reads 0 after that, so writes in the four cycles following the opening write are inside the window.
- R4: A write with bit 4 set while the window is open restarts the four-cycle window from that write.
- R5: A write with bit 3 clear disables the watchdog only when the window is open. Outside the window it leaves the enable unchanged.
- R6: A write with bit 3 set always enables the watchdog.
- R7: The level is 2 when `always_on_cfg` is 1. It is 0 when `compat_cfg` is 1 and `always_on_cfg` is 0. It is 1 when both inputs are 0.
- R8: At level 2 the watchdog stays enabled and bit 3 reads 1 under every write sequence.
- R9: At levels 1 and 2, a write changes the prescaler only inside the window. At level 0 every write updates the prescaler.
- R10: A write with bit 4 clear that lands inside the window closes the window at once.
- R11: While the watchdog is enabled and is not kicked or reconfigured, `timeout_pulse` is high for one cycle in every 2^(BASE_EXP+prescaler) cycles. A `kick` restarts the count from zero.
- R12: An accepted change of the enable or prescaler restarts the count. While the watchdog is disabled the count holds and no pulse is emitted.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Asynchronous reset, active low |
| wr_en | input | 1 | Register write strobe |
| wr_data | input | 8 | Write data |
| compat_cfg | input | 1 | Static configuration: compatibility select |
| always_on_cfg | input | 1 | Static configuration: watchdog forced on |
| kick | input | 1 | Watchdog restart pulse |
| rd_data | output | 8 | Register read value |
| wd_active | output | 1 | Effective watchdog enable |
| period_sel | output | 3 | Prescaler select in use |
| timeout_pulse | output | 1 | One-cycle pulse when the count expires |

## Verification
Every result of a write is due one clock after the edge that samples it: the read value, the enable, the prescaler and a restart of the count. The opened window is visible for four cycles and is gone on the fifth. A timeout pulse appears on the edge at which the count reaches its limit. The bench drives inputs and samples outputs on falling edges. It updates a behavioural model at each rising edge and compares every output against that model on the next falling edge. On top of that, directed checks probe the window at its last accepted cycle and at its first rejected cycle, and count pulses over spans that are whole multiples of the period.

// File: rtl/wdog_cfg_reg.sv
module wdog_cfg_reg #(
  parameter int BASE_EXP = 14
) (
  input  logic       clk,
  input  logic       rst_n,
  input  logic       wr_en,
  input  logic [7:0] wr_data,
  input  logic       compat_cfg,
  input  logic       always_on_cfg,
  input  logic       kick,
  output logic [7:0] rd_data,
  output logic       wd_active,
  output logic [2:0] period_sel,
  output logic       timeout_pulse
);
  localparam int CW = BASE_EXP + 7;

  logic       ce;
  logic [1:0] ce_left;
  logic       en_bit;
  logic [2:0] ps;
  logic [CW-1:0] cnt;

  wire lvl0 = compat_cfg & ~always_on_cfg;
  wire lvl2 = always_on_cfg;

  wire       en_nxt = wr_en ? (wr_data[3] | (en_bit & ~ce) | lvl2) : en_bit;
  wire [2:0] ps_nxt = (wr_en && (lvl0 || ce)) ? wr_data[2:0] : ps;
  wire       cfg_chg = (en_nxt != en_bit) || (ps_nxt != ps);

  wire [CW:0] lim = {{CW{1'b0}}, 1'b1} << (BASE_EXP + int'(ps));
  wire [CW:0] top = lim - 1'b1;
  wire        at_top = ({1'b0, cnt} == top);

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      ce      <= 1'b0;
      ce_left <= 2'd0;
    end else if (wr_en && wr_data[4]) begin
      ce      <= 1'b1;
      ce_left <= 2'd3;
    end else if (ce && (wr_en || ce_left == 2'd0)) begin
      ce      <= 1'b0;
    end else if (ce) begin
      ce_left <= ce_left - 2'd1;
    end
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      en_bit <= always_on_cfg;
      ps     <= 3'd0;
    end else begin
      en_bit <= en_nxt;
      ps     <= ps_nxt;
    end
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      cnt           <= '0;
      timeout_pulse <= 1'b0;
    end else begin
      timeout_pulse <= 1'b0;
      if (kick || cfg_chg) begin
        cnt <= '0;
      end else if (wd_active) begin
        if (at_top) begin
          cnt           <= '0;
          timeout_pulse <= 1'b1;
        end else begin
          cnt <= cnt + 1'b1;
        end
      end
    end
  end

  assign wd_active  = en_bit | lvl2;
  assign period_sel = ps;
  assign rd_data    = {3'b000, ce, wd_active, ps};
endmodule

// File: rtl/wdog_cfg_reg_chk.sv
module wdog_cfg_reg_chk (
  input logic       clk,
  input logic       rst_n,
  input logic       wr_en,
  input logic [7:0] wr_data,
  input logic       compat_cfg,
  input logic       always_on_cfg,
  input logic [7:0] rd_data,
  input logic       wd_active,
  input logic [2:0] period_sel,
  input logic       timeout_pulse
);
  // R2
  reserved_zero_chk: assert property (@(posedge clk) disable iff (!rst_n)
    rd_data[7:5] == 3'b000);

  // R3
  window_open_src_chk: assert property (@(posedge clk) disable iff (!rst_n)
    $rose(rd_data[4]) |-> $past(wr_en && wr_data[4]));

  // R5
  disable_needs_window_chk: assert property (@(posedge clk) disable iff (!rst_n)
    $fell(wd_active) |-> $past(wr_en && rd_data[4]));

  // R8
  forced_on_chk: assert property (@(posedge clk) disable iff (!rst_n)
    always_on_cfg |-> (wd_active && rd_data[3]));

  // R9
  prescale_guard_chk: assert property (@(posedge clk) disable iff (!rst_n)
    (!$stable(period_sel) && !(compat_cfg && !always_on_cfg)) |-> $past(rd_data[4]));

  // R11
  pulse_single_chk: assert property (@(posedge clk) disable iff (!rst_n)
    timeout_pulse |=> !timeout_pulse);

  // R12
  pulse_when_active_chk: assert property (@(posedge clk) disable iff (!rst_n)
    timeout_pulse |-> $past(wd_active));
endmodule

bind wdog_cfg_reg wdog_cfg_reg_chk chk_i (
  .clk(clk), .rst_n(rst_n), .wr_en(wr_en), .wr_data(wr_data),
  .compat_cfg(compat_cfg), .always_on_cfg(always_on_cfg),
  .rd_data(rd_data), .wd_active(wd_active), .period_sel(period_sel),
  .timeout_pulse(timeout_pulse)
);

// File: tb/wdog_cfg_reg_tb_top.sv
module wdog_cfg_reg_tb_top;
  localparam int BE = 2;

  logic       clk = 1'b0;
  logic       rst_n = 1'b0;
  logic       wr_en = 1'b0;
  logic [7:0] wr_data = 8'h00;
  logic       compat_cfg = 1'b0;
  logic       always_on_cfg = 1'b0;
  logic       kick = 1'b0;
  logic [7:0] rd_data;
  logic       wd_active;
  logic [2:0] period_sel;
  logic       timeout_pulse;

  int checks = 0;
  int failures = 0;
  bit done = 1'b0;
  string cur_req = "R1";

  always #10 clk = ~clk;

  wdog_cfg_reg #(.BASE_EXP(BE)) dut_i (
    .clk(clk), .rst_n(rst_n), .wr_en(wr_en), .wr_data(wr_data),
    .compat_cfg(compat_cfg), .always_on_cfg(always_on_cfg), .kick(kick),
    .rd_data(rd_data), .wd_active(wd_active), .period_sel(period_sel),
    .timeout_pulse(timeout_pulse)
  );

  int       m_win, m_cnt, m_lim;
  bit       m_en, m_to, m_open, m_ne;
  bit [2:0] m_ps, m_np;

  always @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      m_win = 0; m_cnt = 0; m_en = always_on_cfg; m_ps = 0; m_to = 0;
    end else begin
      m_open = (m_win > 0);
      m_ne = m_en;
      m_np = m_ps;
      if (wr_en) begin
        if (wr_data[3]) m_ne = 1;
        else if (m_open && !always_on_cfg) m_ne = 0;
        if ((compat_cfg && !always_on_cfg) || m_open) m_np = wr_data[2:0];
        m_win = wr_data[4] ? 4 : 0;
      end else if (m_win > 0) begin
        m_win--;
      end
      m_lim = 1 << (BE + int'(m_ps));
      m_to = 0;
      if (kick || m_ne != m_en || m_np != m_ps) m_cnt = 0;
      else if (m_en || always_on_cfg) begin
        m_cnt++;
        if (m_cnt == m_lim) begin m_cnt = 0; m_to = 1; end
      end
      m_en = m_ne;
      m_ps = m_np;
    end
  end

  task automatic chk(string tag, int act, int exp);
    checks++;
    if (act != exp) begin
      failures++;
      $display("FAIL %s act=%0h exp=%0h", tag, act, exp);
    end
  endtask

  always @(negedge clk) begin
    if (rst_n && !done) begin
      chk({cur_req, " model rd_data"}, rd_data,
          {3'b000, m_win > 0, m_en | always_on_cfg, m_ps});
      chk({cur_req, " model wd_active"}, wd_active, m_en | always_on_cfg);
      chk({cur_req, " model period_sel"}, period_sel, m_ps);
      chk({cur_req, " model timeout_pulse"}, timeout_pulse, m_to);
    end
  end

  task automatic wr(logic [7:0] d);
    wr_en = 1'b1; wr_data = d;
    @(negedge clk);
    wr_en = 1'b0; wr_data = 8'h00;
  endtask

  task automatic idle(int n);
    repeat (n) @(negedge clk);
  endtask

  task automatic do_reset(bit c, bit a, int exp_rd);
    rst_n = 1'b0; compat_cfg = c; always_on_cfg = a;
    idle(3);
    cur_req = "R1";
    chk("R1 reset rd_data", rd_data, exp_rd);
    // R7: level decode shows in the reset enable
    chk("R7 reset wd_active", wd_active, exp_rd[3]);
    rst_n = 1'b1;
    @(negedge clk);
  endtask

  task automatic count_pulses(int n, output int k);
    k = 0;
    repeat (n) begin
      @(negedge clk);
      if (timeout_pulse) k++;
    end
  endtask

  int np;

  initial begin
    do_reset(1'b0, 1'b0, 8'h00);
    cur_req = "R6";
    wr(8'h08);
    chk("R6 enable set", wd_active, 1);
    cur_req = "R11";
    count_pulses(64, np);
    chk("R11 pulses ps0", np, 16);
    kick = 1'b1; @(negedge clk); kick = 1'b0;
    idle(2);
    cur_req = "R5";
    wr(8'h00);
    chk("R5 disable outside window ignored", wd_active, 1);
    cur_req = "R9";
    wr(8'h0D);
    chk("R9 prescaler locked lvl1", period_sel, 0);
    cur_req = "R2";
    wr(8'hF8);
    chk("R2 reserved bits zero", rd_data, 8'h18);
    idle(4);
    chk("R3 window closed after four", rd_data[4], 0);
    cur_req = "R3";
    wr(8'h18);
    idle(3);
    chk("R3 window still open cycle4", rd_data[4], 1);
    wr(8'h03);
    chk("R5 disable in window", wd_active, 0);
    chk("R9 prescaler via window", period_sel, 3);
    cur_req = "R12";
    count_pulses(100, np);
    chk("R12 no pulse while disabled", np, 0);
    wr(8'h0B);
    cur_req = "R11";
    count_pulses(128, np);
    chk("R11 pulses ps3", np, 4);
    cur_req = "R3";
    wr(8'h18);
    idle(4);
    wr(8'h00);
    chk("R3 write after window rejected", wd_active, 1);
    cur_req = "R4";
    wr(8'h18);
    idle(3);
    wr(8'h18);
    idle(3);
    wr(8'h00);
    chk("R4 restarted window accepted", wd_active, 0);
    cur_req = "R10";
    wr(8'h18);
    wr(8'h08);
    chk("R10 window closed by write", rd_data[4], 0);
    wr(8'h00);
    chk("R10 later disable rejected", wd_active, 1);
    cur_req = "R12";
    idle(3);
    wr(8'h18);
    wr(8'h09);
    idle(20);

    do_reset(1'b1, 1'b0, 8'h00);
    cur_req = "R9";
    wr(8'h06);
    chk("R9 free prescaler lvl0", period_sel, 6);
    chk("R7 lvl0 starts off", wd_active, 0);
    wr(8'h08);
    cur_req = "R5";
    wr(8'h00);
    chk("R5 lvl0 disable needs window", wd_active, 1);
    wr(8'h18);
    wr(8'h00);
    chk("R5 lvl0 window disable", wd_active, 0);

    do_reset(1'b0, 1'b1, 8'h08);
    cur_req = "R8";
    count_pulses(64, np);
    chk("R11 lvl2 pulses", np, 16);
    wr(8'h00);
    chk("R8 lvl2 plain clear", wd_active, 1);
    wr(8'h18);
    wr(8'h00);
    chk("R8 lvl2 window clear", rd_data[3], 1);
    cur_req = "R9";
    wr(8'h0A);
    chk("R9 lvl2 locked", period_sel, 0);
    wr(8'h18);
    wr(8'h0A);
    chk("R9 lvl2 window", period_sel, 2);
    do_reset(1'b1, 1'b1, 8'h08);
    cur_req = "R7";
    chk("R7 both set is lvl2", wd_active, 1);
    wr(8'h05);
    chk("R7 lvl2 locks prescaler", period_sel, 0);
    idle(10);

    done = 1'b1;
    $display("TB_RESULT checks=%0d failures=%0d", checks, failures);
    $finish;
  end

  initial begin
    repeat (200000) @(posedge clk);
    if (!done) begin
      done = 1'b1;
      failures++;
      $display("FAIL watchdog act=timeout exp=finish");
      $display("TB_RESULT checks=%0d failures=%0d", checks, failures);
      $finish;
    end
  end
endmodule